// File: doc/BRIEF.md
# Adaptive Fetch Thread Selector

The selector decides, every clock cycle, which hardware thread of a simultaneous-multithreading core may fetch. For each thread it keeps saturating counters fed by increment and decrement strobes from the pipeline. One counter tracks instructions in the front-end stages and the issue queues. One tracks branches in those same stages. One tracks outstanding data-cache misses. A policy input chooses which measure sets priority. The choices are plain rotation, fewest instructions in flight, fewest branches in flight, fewest outstanding misses, or issue-queue position. Under the issue-queue position policy, the thread whose oldest queued instruction sits closest to the queue head gets the lowest priority.

Only threads marked eligible take part. Among the eligible threads, the one with the smallest priority key wins. A rotating pointer breaks ties, and it moves to the thread just after each winner. The grant is combinational from the registered counters and pointer. A strobe therefore affects the grant in the cycle after the edge that samples it.

Top module: `smt_fetch_sel`

## Requirements
- R1: `grant_o` has at most one bit set. A set bit is always at an eligible thread. When `elig_i` is all zero, `grant_o` is zero.
- R2: With `policy_i` = 0 (rotation), all keys are equal. The eligible threads are granted in cyclic index order, starting at the tie pointer.
- R3: With `policy_i` = 1, the eligible thread with the smallest count of front-end and issue-queue instructions is granted. The count is raised by `inst_inc_i[t]` and lowered by `inst_dec_i[t]`.
- R4: With `policy_i` = 2, the eligible thread with the fewest branches in flight is granted. The count is raised by `br_inc_i[t]` and lowered by `br_dec_i[t]`.
- R5: With `policy_i` = 3, the eligible thread with the fewest outstanding data-cache misses is granted. The count is raised by `miss_inc_i[t]` and lowered by `miss_dec_i[t]`.
- R6: With `policy_i` = 4, no counter is used. A thread with `iq_has_i[t]` = 0 has key 0. Otherwise its key is 2^POS_W-1 minus its distance from the queue head, where the distance is `iq_dist_i[t*POS_W +: POS_W]`. The smallest key wins, so the thread nearest the head loses.
- R7: Among the eligible threads with the equal smallest key, the first one found scanning upward from the tie pointer (cyclically) wins. After each cycle with a grant, the pointer is set to the granted index plus one, modulo NUM_THR.
- R8: A counter at 2^CNT_W-1 stays there on a lone increment and never wraps to zero.
- R9: A counter at zero stays at zero on a lone decrement and never wraps to its maximum.
- R10: An increment and a decrement on the same counter in the same cycle leave it unchanged.
- R11: The unused `policy_i` codes 5, 6 and 7 behave exactly like rotation (code 0).
- R12: After reset, all counters are zero and the tie pointer is at thread 0. With all threads eligible, thread 0 is granted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| policy_i | input | 3 | Priority policy select |
| elig_i | input | NUM_THR | Per-thread eligibility |
| inst_inc_i | input | NUM_THR | Instruction enters front end |
| inst_dec_i | input | NUM_THR | Instruction leaves issue queue |
| br_inc_i | input | NUM_THR | Branch enters front end |
| br_dec_i | input | NUM_THR | Branch leaves issue queue |
| miss_inc_i | input | NUM_THR | Data-cache miss starts |
| miss_dec_i | input | NUM_THR | Data-cache miss completes |
| iq_has_i | input | NUM_THR | Thread has an instruction in the issue queues |
| iq_dist_i | input | NUM_THR*POS_W | Per-thread distance of oldest queued instruction from head |
| grant_o | output | NUM_THR | One-hot fetch grant |

## Verification
The bench builds the block with NUM_THR = 4, CNT_W = 3 and POS_W = 3. A three-bit counter reaches its ceiling after seven increments. This makes saturation, underflow at zero and wrap-around mutations visible through the grant within a few cycles. Four threads are enough to exercise multi-way ties, pointer wrap from the last thread back to the first, and eligibility masks that skip threads. With a three-bit distance, every queue position key can be reached.

// File: rtl/smt_fetch_pkg.sv
package smt_fetch_pkg;
  typedef enum logic [2:0] {
    POL_ROTATE = 3'd0,
    POL_INSTS  = 3'd1,
    POL_BRANCH = 3'd2,
    POL_MISS   = 3'd3,
    POL_QPOS   = 3'd4
  } policy_e;

  function automatic int max_int(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/smt_sat_counter.sv
module smt_sat_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (inc_i && !dec_i && cnt_q != CntMax) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec_i && !inc_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CntMax) |=> (cnt_q != '0));
  // R9
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |=> (cnt_q != CntMax));
  // R10
  inc_dec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/smt_key_select.sv
module smt_key_select
  import smt_fetch_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int POS_W = 4,
  parameter int KEY_W = 6
) (
  input  logic [2:0]       policy_i,
  input  logic [CNT_W-1:0] inst_cnt_i,
  input  logic [CNT_W-1:0] br_cnt_i,
  input  logic [CNT_W-1:0] miss_cnt_i,
  input  logic             iq_has_i,
  input  logic [POS_W-1:0] iq_dist_i,
  output logic [KEY_W-1:0] key_o
);
  localparam logic [POS_W-1:0] PosMax = '1;

  policy_e pol;
  assign pol = policy_e'(policy_i);

  always_comb begin
    key_o = '0;
    case (pol)
      POL_INSTS:  key_o = KEY_W'(inst_cnt_i);
      POL_BRANCH: key_o = KEY_W'(br_cnt_i);
      POL_MISS:   key_o = KEY_W'(miss_cnt_i);
      // nearest to head -> largest key -> lowest priority
      POL_QPOS:   key_o = iq_has_i ? KEY_W'(PosMax - iq_dist_i) : '0;
      default:    key_o = '0;
    endcase
  end
endmodule

// File: rtl/smt_rr_min_arbiter.sv
module smt_rr_min_arbiter #(
  parameter int NUM_THR = 4,
  parameter int KEY_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_THR-1:0] elig_i,
  input  logic [KEY_W-1:0] key_i [NUM_THR],
  output logic [NUM_THR-1:0] grant_o
);
  localparam int PTR_W = (NUM_THR > 1) ? $clog2(NUM_THR) : 1;
  localparam logic [PTR_W-1:0] LastIdx = PTR_W'(NUM_THR - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] win_idx;
  logic             found;
  logic [KEY_W-1:0] best_key;

  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    best_key = '0;
    for (int k = 0; k < NUM_THR; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= NUM_THR) idx = idx - NUM_THR;
      if (elig_i[idx] && (!found || key_i[idx] < best_key)) begin
        found    = 1'b1;
        win_idx  = PTR_W'(idx);
        best_key = key_i[idx];
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (found) grant_o[win_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (found) begin
      ptr_q <= (win_idx == LastIdx) ? '0 : win_idx + 1'b1;
    end
  end

  // R1
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  // R1
  grant_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o & ~elig_i) == '0));
  // R1
  grant_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|elig_i) |-> (|grant_o));
  // R7
  ptr_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |=> (ptr_q == (($past(win_idx) == LastIdx) ? '0 : $past(win_idx) + 1'b1)));
endmodule

// File: rtl/smt_fetch_sel.sv
module smt_fetch_sel
  import smt_fetch_pkg::*;
#(
  parameter int NUM_THR = 4,
  parameter int CNT_W   = 6,
  parameter int POS_W   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [2:0]               policy_i,
  input  logic [NUM_THR-1:0]       elig_i,
  input  logic [NUM_THR-1:0]       inst_inc_i,
  input  logic [NUM_THR-1:0]       inst_dec_i,
  input  logic [NUM_THR-1:0]       br_inc_i,
  input  logic [NUM_THR-1:0]       br_dec_i,
  input  logic [NUM_THR-1:0]       miss_inc_i,
  input  logic [NUM_THR-1:0]       miss_dec_i,
  input  logic [NUM_THR-1:0]       iq_has_i,
  input  logic [NUM_THR*POS_W-1:0] iq_dist_i,
  output logic [NUM_THR-1:0]       grant_o
);
  localparam int KEY_W = max_int(CNT_W, POS_W);

  logic [KEY_W-1:0] key [NUM_THR];

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic [CNT_W-1:0] inst_cnt, br_cnt, miss_cnt;

    smt_sat_counter #(.CNT_W(CNT_W)) u_inst_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .inc_i(inst_inc_i[t]), .dec_i(inst_dec_i[t]), .cnt_o(inst_cnt));
    smt_sat_counter #(.CNT_W(CNT_W)) u_br_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .inc_i(br_inc_i[t]), .dec_i(br_dec_i[t]), .cnt_o(br_cnt));
    smt_sat_counter #(.CNT_W(CNT_W)) u_miss_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .inc_i(miss_inc_i[t]), .dec_i(miss_dec_i[t]), .cnt_o(miss_cnt));

    smt_key_select #(.CNT_W(CNT_W), .POS_W(POS_W), .KEY_W(KEY_W)) u_key (
      .policy_i  (policy_i),
      .inst_cnt_i(inst_cnt),
      .br_cnt_i  (br_cnt),
      .miss_cnt_i(miss_cnt),
      .iq_has_i  (iq_has_i[t]),
      .iq_dist_i (iq_dist_i[t*POS_W +: POS_W]),
      .key_o     (key[t]));
  end

  smt_rr_min_arbiter #(.NUM_THR(NUM_THR), .KEY_W(KEY_W)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .elig_i (elig_i),
    .key_i  (key),
    .grant_o(grant_o));
endmodule

// File: tb/smt_fetch_sel_test.sv
module smt_fetch_sel_test;
  localparam int N = 4;
  localparam int CW = 3;
  localparam int PW = 3;
  localparam int CMAX = 7;
  localparam int PMAX = 7;

  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] policy = 0;
  logic [N-1:0] elig = 0, i_inc = 0, i_dec = 0, b_inc = 0, b_dec = 0, m_inc = 0, m_dec = 0, iq_has = 0;
  logic [N*PW-1:0] iq_dist = 0;
  logic [N-1:0] grant;

  int vectors = 0, errors = 0;
  int icnt[N], bcnt[N], mcnt[N];
  int ptr;

  always #10 clk = ~clk;

  smt_fetch_sel #(.NUM_THR(N), .CNT_W(CW), .POS_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .elig_i(elig),
    .inst_inc_i(i_inc), .inst_dec_i(i_dec), .br_inc_i(b_inc), .br_dec_i(b_dec),
    .miss_inc_i(m_inc), .miss_dec_i(m_dec), .iq_has_i(iq_has), .iq_dist_i(iq_dist),
    .grant_o(grant));

  function automatic int key_of(int t);
    case (policy)
      3'd1: return icnt[t];
      3'd2: return bcnt[t];
      3'd3: return mcnt[t];
      3'd4: return iq_has[t] ? PMAX - int'(iq_dist[t*PW +: PW]) : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [N-1:0] exp_grant();
    logic [N-1:0] g = '0;
    int best = -1, bk = 0;
    for (int k = 0; k < N; k++) begin
      int idx = (ptr + k) % N;
      if (elig[idx] && (best < 0 || key_of(idx) < bk)) begin
        best = idx; bk = key_of(idx);
      end
    end
    if (best >= 0) g[best] = 1'b1;
    return g;
  endfunction

  function automatic int upd(int c, logic inc, logic dec);
    if (inc && !dec && c < CMAX) return c + 1;
    if (dec && !inc && c > 0) return c - 1;
    return c;
  endfunction

  task automatic check(string tag, logic [N-1:0] exp);
    vectors++;
    if (grant !== exp) begin
      errors++;
      $display("FAIL %s: grant=%b expected=%b", tag, grant, exp);
    end
  endtask

  // inputs already driven after a negedge; check, clock, update model, clear strobes
  task automatic cycle(string tag);
    logic [N-1:0] e;
    #2;
    e = exp_grant();
    check(tag, e);
    @(posedge clk);
    for (int t = 0; t < N; t++) begin
      icnt[t] = upd(icnt[t], i_inc[t], i_dec[t]);
      bcnt[t] = upd(bcnt[t], b_inc[t], b_dec[t]);
      mcnt[t] = upd(mcnt[t], m_inc[t], m_dec[t]);
    end
    for (int t = 0; t < N; t++) if (e[t]) ptr = (t + 1) % N;
    @(negedge clk);
    i_inc = 0; i_dec = 0; b_inc = 0; b_dec = 0; m_inc = 0; m_dec = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    i_inc = 0; i_dec = 0; b_inc = 0; b_dec = 0; m_inc = 0; m_dec = 0;
    iq_has = 0; iq_dist = 0; policy = 0; elig = 0;
    for (int t = 0; t < N; t++) begin icnt[t] = 0; bcnt[t] = 0; mcnt[t] = 0; end
    ptr = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset_state();
    do_reset();
    elig = '1;
    #2;
    check("R12 reset grant", 4'b0001);
  endtask

  task automatic t_rotate();
    do_reset();
    elig = '1;
    for (int i = 0; i < 6; i++) cycle("R2 rotate all");
    elig = 4'b1010;
    for (int i = 0; i < 4; i++) cycle("R2 rotate masked");
    elig = 4'b0000;
    cycle("R1 none eligible");
    elig = 4'b0100;
    cycle("R1 single eligible");
  endtask

  task automatic t_insts();
    do_reset();
    policy = 3'd1; elig = '1;
    i_inc = 4'b1111; cycle("R3 load");
    i_inc = 4'b1011; cycle("R3 load");
    i_inc = 4'b0001; cycle("R3 load");
    for (int i = 0; i < 3; i++) cycle("R3 min insts");
    i_dec = 4'b0001; cycle("R3 dec");
    i_dec = 4'b0001; cycle("R3 dec");
    for (int i = 0; i < 3; i++) cycle("R7 tie rotate");
    elig = 4'b1001;
    cycle("R3 masked min");
  endtask

  task automatic t_branch_miss();
    do_reset();
    policy = 3'd2; elig = '1;
    b_inc = 4'b0111; cycle("R4 load");
    b_inc = 4'b0011; cycle("R4 load");
    i_inc = 4'b1000; cycle("R4 insts ignored");
    cycle("R4 fewest branches");
    policy = 3'd3;
    m_inc = 4'b1110; cycle("R5 load");
    m_inc = 4'b0100; cycle("R5 load");
    cycle("R5 fewest misses");
    m_dec = 4'b0100; cycle("R5 dec");
    m_dec = 4'b0100; cycle("R5 dec");
    cycle("R5 after completes");
  endtask

  task automatic t_qpos();
    do_reset();
    policy = 3'd4; elig = '1;
    iq_has = 4'b1111;
    iq_dist = {3'd1, 3'd6, 3'd0, 3'd3};
    cycle("R6 farthest wins");
    cycle("R6 farthest wins");
    iq_has = 4'b1011;
    cycle("R6 empty queue first");
    iq_dist = {3'd7, 3'd6, 3'd0, 3'd7};
    iq_has = 4'b1111;
    for (int i = 0; i < 3; i++) cycle("R7 qpos tie");
  endtask

  task automatic t_saturate();
    do_reset();
    policy = 3'd1; elig = 4'b0011;
    for (int i = 0; i < 9; i++) begin i_inc = 4'b0001; cycle("R8 fill t0"); end
    for (int i = 0; i < 7; i++) begin i_inc = 4'b0010; cycle("R8 fill t1"); end
    i_dec = 4'b0010; cycle("R8 dec t1");
    cycle("R8 saturated t0 loses");
    cycle("R8 saturated t0 loses");
  endtask

  task automatic t_floor_both();
    do_reset();
    policy = 3'd3; elig = 4'b0011;
    for (int i = 0; i < 3; i++) begin m_dec = 4'b0001; cycle("R9 dec at zero"); end
    m_inc = 4'b0011; cycle("R9 inc");
    m_inc = 4'b0010; cycle("R9 inc");
    cycle("R9 floor held");
    m_inc = 4'b0001; m_dec = 4'b0001; cycle("R10 inc+dec");
    m_inc = 4'b0001; m_dec = 4'b0001; cycle("R10 inc+dec");
    cycle("R10 unchanged");
    cycle("R10 unchanged");
  endtask

  task automatic t_unused_codes();
    do_reset();
    policy = 3'd1; elig = '1;
    i_inc = 4'b0111; cycle("R11 load");
    for (int c = 5; c < 8; c++) begin
      policy = 3'(c);
      for (int i = 0; i < 4; i++) cycle("R11 acts as rotate");
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: timeout expired expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_rotate();
    t_insts();
    t_branch_miss();
    t_qpos();
    t_saturate();
    t_floor_both();
    t_unused_codes();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule